// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block decides which low-power state the chip takes when the CPU issues a wait-for-interrupt or wait-for-event request, and it sequences the power outputs on the way in and on the way out. Three states are offered. Sleep stops only the CPU clock. Deep-sleep gates every core-domain clock and turns off every oscillator and the PLL, while the regulator stays on in either normal or low-power mode. Standby removes core-domain power and shuts the regulator down.

Wakeup qualification follows the way the state was entered. A wait-for-interrupt entry wakes on any external-line interrupt. A wait-for-event entry wakes on external-line events, and also on interrupts when the send-event-on-pending control is set. Standby has its own wake sources, and its exit ends in a power-on reset of the core. An entry into Deep-sleep or Standby is dropped with no effect when any pending flag is set. The CPU, the oscillators and the regulator are modelled only as enables and ready handshakes.

Top module: `lp_seq_ctrl`

## Requirements
- R1: After reset the block is in the run state. CPU clock, core clock, the 8 MHz RC (`rc8_en_o`), the other oscillators and PLL (`aux_osc_en_o`), regulator enable and core power are all 1. `ldo_lp_o`, `por_rst_o`, `wuf_o`, `stby_flag_o`, `abort_o` and `sysclk_rc8_o` are 0, and `wake_src_o` is 0.
- R2: A `wfi_i` or `wfe_i` pulse with `deep_req_i`=0 enters Sleep on the next cycle. In Sleep `cpu_clk_en_o`=0, while the core clock and all oscillators stay enabled. A qualifying wakeup returns to run on the next cycle, with no `sysclk_rc8_o` pulse.
- R3: A request with `deep_req_i`=1, `stby_sel_i`=0 and no pending flag enters Deep-sleep. CPU clock, core clock, `rc8_en_o` and `aux_osc_en_o` go to 0, while `ldo_en_o` and `core_pwr_o` stay at 1. `ldo_lp_o` equals `ldo_lp_sel_i` as captured at entry.
- R4: After a wait-for-interrupt entry (`wfi_i` wins if both are pulsed), only `ext_irq_i` wakes the block. `ext_evt_i` has no effect.
- R5: After a wait-for-event entry, `ext_evt_i` wakes the block. `ext_irq_i` wakes it only while `sev_on_pend_i`=1.
- R6: A Deep-sleep or Standby request made while `pend_any_i`=1 is skipped. The state stays in run with all outputs unchanged, and `abort_o` pulses high for exactly one cycle.
- R7: On a Deep-sleep wakeup with low-power regulator, `rc8_en_o` returns after LP_DLY+1 cycles; with normal regulator it returns in the same cycle as the wakeup. The CPU clock returns only on the cycle after `osc_ready_i` is seen high. `sysclk_rc8_o` pulses for one cycle on the first run cycle.
- R8: A request with `deep_req_i`=1, `stby_sel_i`=1, no pending flag and `wuf_o`=0 enters Standby. `ldo_en_o`, `core_pwr_o`, all clocks and all oscillators go to 0, while `por_rst_o` and `stby_flag_o` go to 1. With `wuf_o`=1 the request aborts as in R6.
- R9: Standby is left only on `ext_rst_i`, `rtc_evt_i`, `wdg_rst_i` or a rising edge on a wakeup pin whose `wkup_en_i` bit is 1. Interrupts, events and disabled pins have no effect.
- R10: Wakeup pins pass through a two-flop synchronizer and an edge detector. A pin that is already high at Standby entry does not wake the block until it falls and rises again.
- R11: On Standby exit, power and regulator return while `por_rst_o` stays high. After REG_DLY+1 cycles `rc8_en_o` returns. Once the oscillator is ready, `por_rst_o` drops, the CPU clock returns and `sysclk_rc8_o` pulses. `wuf_o` is set to 1, and `wake_src_o` latches the cause: bit0 reset pin, bit1 RTC, bit2 watchdog, bit3 wakeup pin.
- R12: A `flag_clr_i` pulse clears `wuf_o`, `wake_src_o` and `stby_flag_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wfi_i | input | 1 | Wait-for-interrupt request pulse |
| wfe_i | input | 1 | Wait-for-event request pulse |
| deep_req_i | input | 1 | Deep low-power request control |
| stby_sel_i | input | 1 | Select Standby instead of Deep-sleep |
| ldo_lp_sel_i | input | 1 | Regulator low-power select for Deep-sleep |
| sev_on_pend_i | input | 1 | Let interrupts wake a wait-for-event entry |
| pend_any_i | input | 1 | OR of all line pending and peripheral flags |
| ext_irq_i | input | 1 | Any external-line interrupt |
| ext_evt_i | input | 1 | Any external-line wakeup event |
| ext_rst_i | input | 1 | Reset pin asserted |
| rtc_evt_i | input | 1 | RTC alarm, time-stamp or tamper event |
| wdg_rst_i | input | 1 | Watchdog reset |
| wkup_pin_i | input | N_PIN | Asynchronous wakeup pins |
| wkup_en_i | input | N_PIN | Per-pin wakeup enable |
| flag_clr_i | input | 1 | Clear wakeup and standby flags |
| osc_ready_i | input | 1 | 8 MHz RC oscillator ready |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| core_clk_en_o | output | 1 | Core-domain clock gate enable |
| rc8_en_o | output | 1 | 8 MHz RC oscillator enable |
| aux_osc_en_o | output | 1 | 28 MHz RC, crystal and PLL enable |
| ldo_en_o | output | 1 | Regulator enable |
| ldo_lp_o | output | 1 | Regulator low-power mode |
| core_pwr_o | output | 1 | Core-domain power switch |
| por_rst_o | output | 1 | Core power-on reset |
| sysclk_rc8_o | output | 1 | One-cycle force of system clock to 8 MHz RC |
| abort_o | output | 1 | One-cycle pulse: entry skipped |
| stby_flag_o | output | 1 | Standby was entered |
| wuf_o | output | 1 | Standby wakeup occurred |
| wake_src_o | output | 4 | Latched Standby wakeup cause |

## Verification
The checker assumes that `flag_clr_i` is never pulsed while the block sits in Standby. It also assumes that `osc_ready_i` is only high while `rc8_en_o` has been high for a while. The bench models the oscillator as a three-cycle delay of `rc8_en_o`, and it clears the flags only in the run state. Request and wake inputs are single-cycle pulses driven on the falling edge. The wakeup pins are raised and lowered for several cycles each, so that the synchronizer sees every level.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_SLEEP, ST_DSLP, ST_LDO_WAIT, ST_OSC_WAIT, ST_STBY, ST_PWR_UP, ST_POR_OSC
  } lp_state_e;

  localparam int SRC_W   = 4;
  localparam int SRC_RST = 0;
  localparam int SRC_RTC = 1;
  localparam int SRC_WDG = 2;
  localparam int SRC_PIN = 3;
endpackage

// File: rtl/lp_wkup_sync.sv
module lp_wkup_sync #(
  parameter int N_PIN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIN-1:0] pin_i,
  input  logic [N_PIN-1:0] en_i,
  output logic             rise_o
);
  logic [N_PIN-1:0] rise;

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pin_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise[g] = s2_q & ~s3_q & en_i[g];
  end

  assign rise_o = |rise;
endmodule

// File: rtl/lp_dly_cnt.sv
module lp_dly_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lp_wake_qual.sv
module lp_wake_qual (
  input  logic ent_wfe_i,
  input  logic sev_on_pend_i,
  input  logic irq_i,
  input  logic evt_i,
  output logic wake_o
);
  // event-wait entry takes events, interrupts only with send-event-on-pending
  assign wake_o = ent_wfe_i ? (evt_i | (sev_on_pend_i & irq_i)) : irq_i;
endmodule

// File: rtl/lp_seq_ctrl.sv
module lp_seq_ctrl
  import lp_seq_pkg::*;
#(
  parameter int N_PIN   = 2,
  parameter int LP_DLY  = 16,
  parameter int REG_DLY = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wfi_i,
  input  logic             wfe_i,
  input  logic             deep_req_i,
  input  logic             stby_sel_i,
  input  logic             ldo_lp_sel_i,
  input  logic             sev_on_pend_i,
  input  logic             pend_any_i,
  input  logic             ext_irq_i,
  input  logic             ext_evt_i,
  input  logic             ext_rst_i,
  input  logic             rtc_evt_i,
  input  logic             wdg_rst_i,
  input  logic [N_PIN-1:0] wkup_pin_i,
  input  logic [N_PIN-1:0] wkup_en_i,
  input  logic             flag_clr_i,
  input  logic             osc_ready_i,
  output logic             cpu_clk_en_o,
  output logic             core_clk_en_o,
  output logic             rc8_en_o,
  output logic             aux_osc_en_o,
  output logic             ldo_en_o,
  output logic             ldo_lp_o,
  output logic             core_pwr_o,
  output logic             por_rst_o,
  output logic             sysclk_rc8_o,
  output logic             abort_o,
  output logic             stby_flag_o,
  output logic             wuf_o,
  output logic [SRC_W-1:0] wake_src_o
);
  localparam int MAX_DLY = (LP_DLY > REG_DLY) ? LP_DLY : REG_DLY;
  localparam int CNT_W   = $clog2(MAX_DLY + 2);

  lp_state_e        state_q, state_d;
  logic             ent_wfe_q, ldo_lp_q, wuf_q, stby_q, force_q, abort_q;
  logic [SRC_W-1:0] src_q, src_now;
  logic             pin_rise, wake_q, cnt_zero, cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             enter, abort_d, force_d, stby_set, stby_wake;

  lp_wkup_sync #(.N_PIN(N_PIN)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(wkup_pin_i), .en_i(wkup_en_i), .rise_o(pin_rise)
  );

  lp_dly_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cnt_load), .val_i(cnt_val), .zero_o(cnt_zero)
  );

  lp_wake_qual u_qual (
    .ent_wfe_i(ent_wfe_q), .sev_on_pend_i(sev_on_pend_i),
    .irq_i(ext_irq_i), .evt_i(ext_evt_i), .wake_o(wake_q)
  );

  always_comb begin
    src_now          = '0;
    src_now[SRC_RST] = ext_rst_i;
    src_now[SRC_RTC] = rtc_evt_i;
    src_now[SRC_WDG] = wdg_rst_i;
    src_now[SRC_PIN] = pin_rise;
  end

  assign stby_wake = |src_now;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    enter    = 1'b0;
    abort_d  = 1'b0;
    force_d  = 1'b0;
    stby_set = 1'b0;
    unique case (state_q)
      ST_RUN: if (wfi_i | wfe_i) begin
        if (!deep_req_i) begin
          state_d = ST_SLEEP;
          enter   = 1'b1;
        end else if (pend_any_i | (stby_sel_i & wuf_q)) begin
          abort_d = 1'b1;
        end else begin
          state_d  = stby_sel_i ? ST_STBY : ST_DSLP;
          enter    = 1'b1;
          stby_set = stby_sel_i;
        end
      end
      ST_SLEEP: if (wake_q) state_d = ST_RUN;
      ST_DSLP: if (wake_q) begin
        if (ldo_lp_q) begin
          state_d  = ST_LDO_WAIT;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(LP_DLY);
        end else begin
          state_d = ST_OSC_WAIT;
        end
      end
      ST_LDO_WAIT: if (cnt_zero) state_d = ST_OSC_WAIT;
      ST_OSC_WAIT: if (osc_ready_i) begin
        state_d = ST_RUN;
        force_d = 1'b1;
      end
      ST_STBY: if (stby_wake) begin
        state_d  = ST_PWR_UP;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(REG_DLY);
      end
      ST_PWR_UP: if (cnt_zero) state_d = ST_POR_OSC;
      ST_POR_OSC: if (osc_ready_i) begin
        state_d = ST_RUN;
        force_d = 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      ent_wfe_q <= 1'b0;
      ldo_lp_q  <= 1'b0;
      wuf_q     <= 1'b0;
      stby_q    <= 1'b0;
      src_q     <= '0;
      force_q   <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      force_q <= force_d;
      abort_q <= abort_d;
      if (enter) begin
        ent_wfe_q <= wfe_i & ~wfi_i;
        ldo_lp_q  <= ldo_lp_sel_i;
      end
      if (flag_clr_i) begin
        wuf_q  <= 1'b0;
        stby_q <= 1'b0;
        src_q  <= '0;
      end
      if (stby_set) stby_q <= 1'b1;
      if (state_q == ST_STBY && stby_wake) begin
        wuf_q <= 1'b1;
        src_q <= src_q | src_now;
      end
    end
  end

  assign cpu_clk_en_o  = (state_q == ST_RUN);
  assign core_clk_en_o = (state_q == ST_RUN) || (state_q == ST_SLEEP);
  assign aux_osc_en_o  = core_clk_en_o;
  assign rc8_en_o      = core_clk_en_o || (state_q == ST_OSC_WAIT) || (state_q == ST_POR_OSC);
  assign ldo_en_o      = (state_q != ST_STBY);
  assign core_pwr_o    = (state_q != ST_STBY);
  assign ldo_lp_o      = (state_q == ST_DSLP) && ldo_lp_q;
  assign por_rst_o     = (state_q == ST_STBY) || (state_q == ST_PWR_UP) || (state_q == ST_POR_OSC);
  assign sysclk_rc8_o  = force_q;
  assign abort_o       = abort_q;
  assign stby_flag_o   = stby_q;
  assign wuf_o         = wuf_q;
  assign wake_src_o    = src_q;
endmodule

// File: rtl/lp_seq_ctrl_chk.sv
module lp_seq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_ready_i,
  input logic       cpu_clk_en_o,
  input logic       core_clk_en_o,
  input logic       ldo_en_o,
  input logic       ldo_lp_o,
  input logic       core_pwr_o,
  input logic       por_rst_o,
  input logic       sysclk_rc8_o,
  input logic       abort_o,
  input logic       stby_flag_o,
  input logic       wuf_o,
  input logic [3:0] wake_src_o
);
  // R7
  cpu_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cpu_clk_en_o) && !$past(core_clk_en_o)) |-> $past(osc_ready_i));
  // R7
  force_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysclk_rc8_o |-> cpu_clk_en_o);
  // R6
  abort_stays_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (cpu_clk_en_o && $stable(cpu_clk_en_o)));
  // R8
  pwr_follows_ldo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldo_en_o |-> (!core_pwr_o && stby_flag_o && por_rst_o));
  // R11
  por_holds_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_rst_o |-> !cpu_clk_en_o);
  // R3
  ldo_lp_in_dslp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldo_lp_o |-> (!core_clk_en_o && ldo_en_o));
  // R11
  wuf_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wuf_o) |-> ($countones(wake_src_o) >= 1));
endmodule

bind lp_seq_ctrl lp_seq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .osc_ready_i(osc_ready_i),
  .cpu_clk_en_o(cpu_clk_en_o), .core_clk_en_o(core_clk_en_o), .ldo_en_o(ldo_en_o),
  .ldo_lp_o(ldo_lp_o), .core_pwr_o(core_pwr_o), .por_rst_o(por_rst_o),
  .sysclk_rc8_o(sysclk_rc8_o), .abort_o(abort_o), .stby_flag_o(stby_flag_o),
  .wuf_o(wuf_o), .wake_src_o(wake_src_o)
);

// File: tb/lp_seq_ctrl_tb.sv
module lp_seq_ctrl_tb;
  localparam int N_PIN = 2, LP_DLY = 5, REG_DLY = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wfi = 0, wfe = 0, deep = 0, stby = 0, ldo_lp = 0, sev = 0, pend = 0;
  logic irq = 0, evt = 0, xrst = 0, rtc = 0, wdg = 0, fclr = 0;
  logic [N_PIN-1:0] pin = '0, pen = '0;
  logic [2:0] osc_sr;
  logic osc_rdy;
  logic cpu, core, rc8, aux, ldo_en, ldo_lpo, pwr, por, force_o, abort, sflag, wuf;
  logic [3:0] src;

  int errs = 0, checks = 0;
  bit done = 0;

  typedef struct { logic [3:0] src; logic wuf; logic por_seen; logic force_v; string req; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) osc_sr <= '0;
    else        osc_sr <= {osc_sr[1:0], rc8};
  assign osc_rdy = osc_sr[2];

  lp_seq_ctrl #(.N_PIN(N_PIN), .LP_DLY(LP_DLY), .REG_DLY(REG_DLY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wfi_i(wfi), .wfe_i(wfe), .deep_req_i(deep),
    .stby_sel_i(stby), .ldo_lp_sel_i(ldo_lp), .sev_on_pend_i(sev), .pend_any_i(pend),
    .ext_irq_i(irq), .ext_evt_i(evt), .ext_rst_i(xrst), .rtc_evt_i(rtc), .wdg_rst_i(wdg),
    .wkup_pin_i(pin), .wkup_en_i(pen), .flag_clr_i(fclr), .osc_ready_i(osc_rdy),
    .cpu_clk_en_o(cpu), .core_clk_en_o(core), .rc8_en_o(rc8), .aux_osc_en_o(aux),
    .ldo_en_o(ldo_en), .ldo_lp_o(ldo_lpo), .core_pwr_o(pwr), .por_rst_o(por),
    .sysclk_rc8_o(force_o), .abort_o(abort), .stby_flag_o(sflag), .wuf_o(wuf),
    .wake_src_o(src)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [3:0] s, input logic w, input logic p, input logic f, input string r);
    exp_t e;
    e.src = s; e.wuf = w; e.por_seen = p; e.force_v = f; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic wait_run();
    for (int i = 0; i < 60 && !cpu; i++) tick();
    repeat (3) tick();
  endtask

  task automatic req_wfi();
    wfi = 1; tick(); wfi = 0;
  endtask

  // monitor: compare each return to run against the next expected wake record
  logic prev_cpu = 1'b1, por_seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cpu) por_seen = por_seen | por;
      if (cpu && !prev_cpu) begin
        if (exp_q.size() == 0) chk(0, "R2 unexpected wake", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(src == e.src, {e.req, " src"}, src, e.src);
          chk(wuf == e.wuf, {e.req, " wuf"}, wuf, e.wuf);
          chk(por_seen == e.por_seen, {e.req, " por"}, por_seen, e.por_seen);
          chk(force_o == e.force_v, {e.req, " force"}, force_o, e.force_v);
        end
        por_seen = 1'b0;
      end
    end
    prev_cpu = cpu;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1;
    repeat (5) tick();
    // R1 reset state
    chk(cpu && core && rc8 && aux && ldo_en && pwr, "R1 on", 0, 1);
    chk(!ldo_lpo && !por && !wuf && !sflag && !abort && !force_o && src == 0, "R1 off", 1, 0);

    // R2 Sleep by wfi, R4 event ignored
    req_wfi();
    chk(!cpu && core && rc8 && aux, "R2 sleep", cpu, 0);
    evt = 1; tick(); evt = 0; repeat (3) tick();
    chk(!cpu, "R4 evt ignored", cpu, 0);
    push(0, 0, 0, 0, "R2/R4 irq wake");
    irq = 1; tick(); irq = 0;
    chk(cpu, "R2 wake next cycle", cpu, 1);
    repeat (3) tick();

    // R5 wfe: irq ignored without sev, evt wakes
    wfe = 1; tick(); wfe = 0;
    irq = 1; tick(); irq = 0; repeat (3) tick();
    chk(!cpu, "R5 irq ignored", cpu, 0);
    push(0, 0, 0, 0, "R5 evt wake");
    evt = 1; tick(); evt = 0; repeat (3) tick();
    // R5 sev lets irq wake
    sev = 1;
    wfe = 1; tick(); wfe = 0;
    push(0, 0, 0, 0, "R5 sev irq wake");
    irq = 1; tick(); irq = 0;
    chk(cpu, "R5 sev irq", cpu, 1);
    sev = 0; repeat (3) tick();

    // R3 Deep-sleep normal regulator, R7 exit
    deep = 1;
    req_wfi();
    chk(!cpu && !core && !rc8 && !aux && ldo_en && pwr && !ldo_lpo, "R3 dslp", core, 0);
    push(0, 0, 0, 1, "R7 dslp exit");
    irq = 1; tick(); irq = 0; n = 1;
    while (!rc8 && n < 40) begin tick(); n++; end
    chk(n == 1, "R7 rc8 normal", n, 1);
    chk(!cpu, "R7 cpu waits ready", cpu, 0);
    wait_run();

    // R3 low-power regulator, R5 wfe in deep-sleep, R7 extra delay
    ldo_lp = 1;
    wfe = 1; tick(); wfe = 0;
    chk(ldo_lpo && ldo_en && !core, "R3 ldo lp", ldo_lpo, 1);
    irq = 1; tick(); irq = 0; repeat (3) tick();
    chk(!cpu && ldo_lpo, "R5 irq ignored dslp", cpu, 0);
    push(0, 0, 0, 1, "R7 lp exit");
    evt = 1; tick(); evt = 0; n = 1;
    while (!rc8 && n < 40) begin tick(); n++; end
    chk(n == LP_DLY + 2, "R7 lp delay", n, LP_DLY + 2);
    wait_run();
    ldo_lp = 0;

    // R6 abort on pending
    pend = 1;
    req_wfi();
    chk(abort && cpu && core && rc8, "R6 abort", abort, 1);
    tick();
    chk(!abort && cpu, "R6 one cycle", abort, 0);
    stby = 1;
    req_wfi();
    chk(abort && ldo_en && !sflag, "R6 stby abort", abort, 1);
    pend = 0; repeat (2) tick();

    // R8 Standby entry, R9/R10 ignored inputs
    pen = 2'b01; pin = 2'b01; repeat (4) tick();
    req_wfi();
    chk(!cpu && !core && !rc8 && !ldo_en && !pwr && por && sflag, "R8 stby", ldo_en, 0);
    irq = 1; evt = 1; tick(); irq = 0; evt = 0; repeat (5) tick();
    chk(!ldo_en, "R9 irq/evt ignored", ldo_en, 0);
    chk(!ldo_en, "R10 static pin ignored", ldo_en, 0);
    pin[1] = 1; repeat (6) tick();
    chk(!ldo_en, "R9 disabled pin ignored", ldo_en, 0);
    pin = 2'b00; repeat (4) tick();
    push(4'b1000, 1, 1, 1, "R11 pin wake");
    pin[0] = 1;
    for (int i = 0; i < 10 && !ldo_en; i++) tick();
    chk(ldo_en && pwr && por && !cpu, "R11 power up", por, 1);
    n = 0;
    while (!rc8 && n < 40) begin tick(); n++; end
    chk(n == REG_DLY + 1, "R11 reg delay", n, REG_DLY + 1);
    wait_run();
    pin = '0;

    // R8 blocked by wuf
    req_wfi();
    chk(abort && cpu, "R8 wuf blocks", abort, 1);
    tick();
    // R12 clear
    fclr = 1; tick(); fclr = 0;
    chk(!wuf && !sflag && src == 0, "R12 clear", wuf, 0);

    // R9 other standby sources
    for (int k = 0; k < 3; k++) begin
      req_wfi();
      repeat (3) tick();
      push(4'(1 << k), 1, 1, 1, "R9 source");
      case (k)
        0: xrst = 1;
        1: rtc = 1;
        default: wdg = 1;
      endcase
      tick();
      xrst = 0; rtc = 0; wdg = 0;
      wait_run();
      fclr = 1; tick(); fclr = 0; tick();
    end

    chk(exp_q.size() == 0, "R9 all wakes seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule